// File: doc/BRIEF.md
# Input Change Detector with Interrupt

This block watches a small group of asynchronous input pins. When a pin settles at a new level, it latches a sticky change flag for that pin. Software reads the change register to get two things at once: the sticky flags in the upper half and the present synchronized pin levels in the lower half. That read also clears the flags.

A status register gathers interrupt sources. Its top bit summarises the change flags, but only for pins whose enable bit is set. Its lower bits come straight from other interrupt sources, which enter as plain input bits. A mask register decides which status bits may pull the active-low interrupt output. The mask never alters what a status read returns.

Software uses a simple register port: a write strobe and a read strobe, a 2-bit address, and a data bus in each direction. Read data and the interrupt pin are both registered. The register addresses are change register at 0, status at 1, pin enables at 2 (bits 3:0) and interrupt mask at 3.

Top module: `pin_change_irq`

## Requirements
- R1: After synchronous reset, `rdata` is 0x00 and `irq_n` is 1. Status, change flags, pin enables and mask are all 0, and the accepted level of every pin is 0.
- R2: A pin is first sampled at clock edge k. If the new level matches the sample at edge k+1 and differs from that pin's accepted level, the pin's change flag is set after edge k+3. Pin i maps to bit 4+i of the change register (address 0).
- R3: A pin pulse that lasts for only one sample sets no change flag.
- R4: Bits 3:0 of a change-register read give the synchronized pin levels, meaning the pin values sampled two edges before the read edge. Bit i is pin i.
- R5: A read of address 0 clears all change flags. If a pin's change is accepted on the same edge as that read, its flag stays set.
- R6: A read of address 1 returns the status byte. Bit 7 is the OR over pins of (change flag AND pin enable). Bits 6:0 are `src_in[6:0]`.
- R7: `irq_n` is 0 in the cycle after any status bit and its mask bit are both 1, and 1 otherwise. The mask has no effect on the value a status read returns.
- R8: Writes to address 2 load the pin enables from `wdata[3:0]`, and writes to address 3 load the 8-bit mask. Both read back at their own addresses, with bits 7:4 of address 2 reading as 0. Writes to addresses 0 and 1 change nothing.
- R9: `rdata` updates on the edge where `rd_en` is 1 and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 4 | Monitored asynchronous pins |
| src_in | input | 7 | Other interrupt sources, status bits 6:0 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A pin change first sampled at edge k reaches the flags and the status summary after edge k+3. It then reaches `irq_n` one edge later. Read data is due just after the edge that carries `rd_en`. The bench reference model advances once per rising edge, using the inputs held across that edge, and counts these same delays in its own sample queue. Its predictions for `rdata` and `irq_n` are compared on the falling edge, half a cycle after the design updates. Directed sequences place a read on the very edge where a change is accepted, apply one-sample glitches and two-sample pulses, and toggle enables and mask around pending flags.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [1:0] {
    ADDR_CHG  = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_EN   = 2'd2,
    ADDR_MASK = 2'd3
  } pcd_addr_e;
endpackage

// File: rtl/pcd_pin_filter.sv
module pcd_pin_filter #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] level_o,
  output logic [NPINS-1:0] chg_o
);
  logic [NPINS-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic lvl_q;
    // accept a new level once two synchronized samples agree
    assign chg_o[g] = (s2_q[g] == s3_q[g]) && (s2_q[g] != lvl_q);
    always_ff @(posedge clk) begin
      if (rst) lvl_q <= 1'b0;
      else if (chg_o[g]) lvl_q <= s2_q[g];
    end
  end

  assign level_o = s2_q;
endmodule

// File: rtl/pcd_flag_bank.sv
module pcd_flag_bank #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] chg_i,
  input  logic             clr_i,
  output logic [NPINS-1:0] flags_o
);
  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= (clr_i ? '0 : flags_o) | chg_i;
  end
endmodule

// File: rtl/pcd_ctrl_regs.sv
module pcd_ctrl_regs
  import pcd_pkg::*;
#(
  parameter int NPINS = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [NPINS-1:0] en_o,
  output logic [DW-1:0]    mask_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= '0;
      mask_o <= '0;
    end else if (wr_en) begin
      case (pcd_addr_e'(addr))
        ADDR_EN:   en_o   <= wdata[NPINS-1:0];
        ADDR_MASK: mask_o <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pcd_pkg::*;
#(
  parameter int NPINS = 4,
  localparam int DW   = 2 * NPINS,
  localparam int NSRC = DW - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NSRC-1:0]  src_in,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq_n
);
  logic [NPINS-1:0] level, chg, flags, en_r;
  logic [DW-1:0]    mask_r, status;
  logic             clr;

  assign clr = rd_en && (pcd_addr_e'(addr) == ADDR_CHG);

  pcd_pin_filter #(.NPINS(NPINS)) u_filt (
    .clk(clk), .rst(rst), .pin_i(pin_in), .level_o(level), .chg_o(chg)
  );

  pcd_flag_bank #(.NPINS(NPINS)) u_flags (
    .clk(clk), .rst(rst), .chg_i(chg), .clr_i(clr), .flags_o(flags)
  );

  pcd_ctrl_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .en_o(en_r), .mask_o(mask_r)
  );

  assign status = {|(flags & en_r), src_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq_n <= 1'b1;
    end else begin
      irq_n <= ~|(status & mask_r);
      if (rd_en) begin
        case (pcd_addr_e'(addr))
          ADDR_CHG:  rdata <= {flags, level};
          ADDR_STAT: rdata <= status;
          ADDR_EN:   rdata <= {{(DW-NPINS){1'b0}}, en_r};
          default:   rdata <= mask_r;
        endcase
      end
    end
  end
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int NPINS = 4,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic [DW-1:0]    rdata,
  input logic             irq_n,
  input logic [NPINS-1:0] chg,
  input logic [NPINS-1:0] flags,
  input logic [DW-1:0]    status,
  input logic [DW-1:0]    mask
);
  // R1
  reset_out_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_n && rdata == '0));
  // R2
  chg_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (|chg) |=> ((flags & $past(chg)) == $past(chg)));
  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd0 && chg == '0) |=> (flags == '0));
  // R7
  irq_assert_chk: assert property (@(posedge clk) disable iff (rst)
    (|(status & mask)) |=> !irq_n);
  // R7
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    ((status & mask) == '0) |=> irq_n);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind pin_change_irq pcd_checker #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .irq_n(irq_n), .chg(chg), .flags(flags), .status(status), .mask(mask_r)
);

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pin_in = '0;
  logic [6:0] src_in = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pin_change_irq u_pin_change_irq (
    .clk(clk), .rst(rst), .pin_in(pin_in), .src_in(src_in), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  // reference model: queue of pin samples, behavioural registers
  logic [3:0] hq[$];
  logic [3:0] m_lvl, m_flag, m_en;
  logic [7:0] m_mask, m_rdata;
  logic       m_irq_n;
  string      m_tag;

  always @(posedge clk) begin
    logic [3:0] s2, s3, c;
    logic [7:0] st;
    if (rst) begin
      hq = '{4'h0, 4'h0, 4'h0};
      m_lvl = '0; m_flag = '0; m_en = '0; m_mask = '0;
      m_rdata = '0; m_irq_n = 1'b1; m_tag = "R1";
    end else begin
      s2 = hq[1];
      s3 = hq[2];
      for (int i = 0; i < 4; i++) c[i] = (s2[i] == s3[i]) && (s2[i] != m_lvl[i]);
      st = {|(m_flag & m_en), src_in};
      if (rd_en) begin
        case (addr)
          2'd0: begin m_rdata = {m_flag, s2}; m_tag = "R2 R4 R5"; end
          2'd1: begin m_rdata = st; m_tag = "R6"; end
          2'd2: begin m_rdata = {4'h0, m_en}; m_tag = "R8"; end
          default: begin m_rdata = m_mask; m_tag = "R8"; end
        endcase
      end else m_tag = "R9";
      m_irq_n = ~|(st & m_mask);
      if (rd_en && addr == 2'd0) m_flag = '0;
      m_flag = m_flag | c;
      for (int i = 0; i < 4; i++) if (c[i]) m_lvl[i] = s2[i];
      if (wr_en && addr == 2'd2) m_en = wdata[3:0];
      if (wr_en && addr == 2'd3) m_mask = wdata;
      hq.push_front(pin_in);
      void'(hq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rdata !== m_rdata) begin
        fails++;
        $display("FAIL %s rdata actual %02h expected %02h", m_tag, rdata, m_rdata);
      end
      checks++;
      if (irq_n !== m_irq_n) begin
        fails++;
        $display("FAIL R7 irq_n actual %0b expected %0b", irq_n, m_irq_n);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic direct(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1: reset values read back
    rd(2'd1); direct("R1 status", rdata, 8'h00);
    rd(2'd3); direct("R1 mask", rdata, 8'h00);
    // R8: config writes and ignored writes
    wr(2'd2, 8'hFF); rd(2'd2); direct("R8 enable", rdata, 8'h0F);
    wr(2'd3, 8'h80); rd(2'd3); direct("R8 mask", rdata, 8'h80);
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); rd(2'd0); direct("R8 ignored write", rdata, 8'h00);
    // R2: pin0 rises
    @(negedge clk); pin_in[0] = 1'b1;
    tick(6);
    rd(2'd0); direct("R2 R4 flag+level", rdata, 8'h11);
    rd(2'd0); direct("R5 cleared", rdata, 8'h01);
    // R3: one-sample glitch on pin1
    @(negedge clk); pin_in[1] = 1'b1;
    @(negedge clk); pin_in[1] = 1'b0;
    tick(6);
    rd(2'd0); direct("R3 glitch", rdata, 8'h01);
    // two-sample pulse on pin2 is accepted both ways
    @(negedge clk); pin_in[2] = 1'b1;
    tick(2); pin_in[2] = 1'b0;
    tick(6);
    rd(2'd0); direct("R2 pulse", rdata, 8'h41);
    // R5: change accepted on the clearing edge wins
    @(negedge clk); pin_in[3] = 1'b1;
    tick(3);
    rd_en = 1'b1; addr = 2'd0;
    @(negedge clk); rd_en = 1'b0;
    rd(2'd0); direct("R5 same-edge", rdata, 8'h89);
    // R6, R7: enable off and mask influence
    @(negedge clk); pin_in[0] = 1'b0;
    tick(6);
    wr(2'd2, 8'h00); rd(2'd1); direct("R6 enable off", rdata, 8'h00);
    wr(2'd2, 8'h01); rd(2'd1); direct("R6 enable on", rdata, 8'h80);
    src_in = 7'h05;
    wr(2'd3, 8'h00); rd(2'd1); direct("R7 mask no effect", rdata, 8'h85);
    direct("R7 irq masked", {7'h0, irq_n}, 8'h01);
    wr(2'd3, 8'h04); tick(1); direct("R7 irq from source", {7'h0, irq_n}, 8'h00);
    src_in = 7'h00; tick(2); direct("R7 irq released", {7'h0, irq_n}, 8'h01);
    tick(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule